// File: doc/BRIEF.md
# Event-Driven Thread Switch Controller

This block governs a scalar pipeline that holds several hardware thread contexts and runs them in coarse-grained fashion. One context owns the pipeline at a time and keeps it until that thread hits a long-latency event or uses up its time quantum. A switch then flushes the outgoing thread's younger in-flight instructions for a fixed number of cycles, during which nothing is fetched. After the flush the controller hands the pipeline to the next eligible context.

A thread that leaves because of an event is parked as waiting until its completion pulse arrives. A thread is eligible when its external ready flag is high and it is not waiting. When no thread is eligible the controller idles with the last thread ID held and resumes as soon as one qualifies. All outputs are plain registered control and status pins. There is no streaming interface, so no valid/ready back-pressure applies.

Top module: `ctsw_ctrl`

## Requirements
- R1: After reset, thread 0 is active and issuing, flush is low, and no thread is waiting.
- R2: While a thread issues, a high level on `ev_miss`, `ev_fpu` or `ev_io` at a clock edge makes flush high and issue low from the next cycle on, and sets bit N of `waiting`, where N is that thread's ID.
- R3: A flush keeps `flush` high for exactly FLUSH_CYCLES consecutive cycles (default 3). During the flush `issue_en` stays low and `active_tid` holds the outgoing thread's ID.
- R4: At the end of a flush, the new thread is the first eligible one in the order cur+1, cur+2, ... modulo the thread count, with the current thread checked last. Eligible means `thr_ready[i]` is high and `waiting[i]` is low.
- R5: If no thread is eligible at the end of a flush, the controller idles with `issue_en` and `flush` low and `active_tid` unchanged. It leaves idle straight to issuing, with no second flush, once a thread is eligible, and picks that thread in the same order as R4.
- R6: A pulse on `ev_done[i]` clears `waiting[i]` in the next cycle.
- R7: With `quantum` = Q > 0, a thread switches out after Q issue cycles without an event, and its waiting bit is left unchanged. This happens only if another thread is eligible. Otherwise the thread keeps issuing and its quantum restarts.
- R8: With `quantum` = 0 the timeout is disabled, and a thread keeps issuing indefinitely.
- R9: The quantum count restarts from zero on every entry into issuing and after every timeout. It counts only cycles in which `issue_en` is high.
- R10: When an event and a quantum expiry fall in the same cycle, the event wins and the thread is marked waiting.
- R11: Event inputs are ignored while `issue_en` is low, during flush and during idle.
- R12: `issue_en` and `flush` are never high together, so at most one thread issues in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_miss | input | 1 | Active thread stalls on a cache miss |
| ev_fpu | input | 1 | Active thread stalls on a long floating-point operation |
| ev_io | input | 1 | Active thread stalls on a slow I/O access |
| ev_done | input | NT | Per-thread pulse: the thread's long-latency event has completed |
| thr_ready | input | NT | Per-thread external ready flag, used only for selection |
| quantum | input | QW | Issue cycles per time slice; 0 disables the timeout |
| active_tid | output | clog2(NT) | ID of the thread that owns the pipeline |
| issue_en | output | 1 | Active thread may fetch and issue this cycle |
| flush | output | 1 | Flush younger in-flight instructions of the active thread |
| waiting | output | NT | Per-thread flag: parked on an outstanding event |

## Verification
The two functions that can collide are the event-driven switch and the quantum timeout. Both are decided in the same issuing cycle. The bench lets a thread run Q-1 issue cycles after a switch and then raises a miss exactly in the cycle the quantum expires. It judges the result by the outgoing thread's waiting bit being set, which a plain timeout would leave clear. A second overlap pairs a timeout with eligibility that vanishes during the flush, and the bench confirms that the outgoing thread resumes.

// File: rtl/ctsw_pkg.sv
package ctsw_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_FLUSH = 2'd1,
    ST_IDLE  = 2'd2
  } ctsw_state_e;
endpackage

// File: rtl/ctsw_pick.sv
// Circular next-thread selector: first eligible after cur, cur itself last.
module ctsw_pick #(
  parameter int NT = 4,
  parameter int TW = 2
) (
  input  logic [TW-1:0] cur,
  input  logic [NT-1:0] elig,
  output logic          found,
  output logic [TW-1:0] nxt
);
  always_comb begin
    found = 1'b0;
    nxt   = cur;
    // walk from farthest to nearest so the nearest candidate is written last
    for (int k = NT; k >= 1; k--) begin
      int idx;
      idx = (int'(cur) + k) % NT;
      if (elig[idx]) begin
        found = 1'b1;
        nxt   = TW'(idx);
      end
    end
  end
endmodule

// File: rtl/ctsw_quantum.sv
// Counts issue cycles of the active thread and flags quantum expiry.
module ctsw_quantum #(
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [QW-1:0] quantum,
  output logic          expire
);
  logic [QW-1:0] cnt;

  assign expire = run && (quantum != '0) &&
                  (({1'b0, cnt} + (QW+1)'(1)) >= {1'b0, quantum});

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || expire) cnt <= '0;
    else                     cnt <= cnt + QW'(1);
  end
endmodule

// File: rtl/ctsw_waitflags.sv
// One parked flag per thread: set on an event switch, cleared on completion.
module ctsw_waitflags #(
  parameter int NT = 4,
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [TW-1:0] set_tid,
  input  logic [NT-1:0] clr,
  output logic [NT-1:0] flags
);
  for (genvar i = 0; i < NT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                                flags[i] <= 1'b0;
      else if (set_en && (set_tid == TW'(i)))    flags[i] <= 1'b1;
      else if (clr[i])                           flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ctsw_ctrl.sv
module ctsw_ctrl
  import ctsw_pkg::*;
#(
  parameter int NT           = 4,
  parameter int FLUSH_CYCLES = 3,
  parameter int QW           = 8,
  localparam int TW          = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_miss,
  input  logic          ev_fpu,
  input  logic          ev_io,
  input  logic [NT-1:0] ev_done,
  input  logic [NT-1:0] thr_ready,
  input  logic [QW-1:0] quantum,
  output logic [TW-1:0] active_tid,
  output logic          issue_en,
  output logic          flush,
  output logic [NT-1:0] waiting
);
  localparam int FW = (FLUSH_CYCLES > 1) ? $clog2(FLUSH_CYCLES) : 1;
  localparam logic [FW-1:0] FLAST = FW'(FLUSH_CYCLES - 1);

  ctsw_state_e   state;
  logic [TW-1:0] tid;
  logic [FW-1:0] fcnt;

  logic          running, ev_hit, q_expire;
  logic [NT-1:0] elig, self_mask;
  logic          oth_found, any_found;
  logic [TW-1:0] any_nxt;

  assign running   = (state == ST_RUN);
  assign ev_hit    = running && (ev_miss || ev_fpu || ev_io);
  assign elig      = thr_ready & ~waiting;
  assign self_mask = NT'(1) << tid;
  assign oth_found = |(elig & ~self_mask);

  ctsw_pick #(.NT(NT), .TW(TW)) u_pick (
    .cur   (tid),
    .elig  (elig),
    .found (any_found),
    .nxt   (any_nxt)
  );

  ctsw_quantum #(.QW(QW)) u_quant (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .quantum (quantum),
    .expire  (q_expire)
  );

  ctsw_waitflags #(.NT(NT), .TW(TW)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (ev_hit),
    .set_tid (tid),
    .clr     (ev_done),
    .flags   (waiting)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_RUN;
      tid   <= '0;
      fcnt  <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          // an event always switches; a timeout only when someone else can run
          if (ev_hit || (q_expire && oth_found)) begin
            state <= ST_FLUSH;
            fcnt  <= '0;
          end
        end
        ST_FLUSH: begin
          if (fcnt == FLAST) begin
            if (any_found) begin
              state <= ST_RUN;
              tid   <= any_nxt;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            fcnt <= fcnt + FW'(1);
          end
        end
        ST_IDLE: begin
          if (any_found) begin
            state <= ST_RUN;
            tid   <= any_nxt;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign active_tid = tid;
  assign issue_en   = running;
  assign flush      = (state == ST_FLUSH);
endmodule

// File: rtl/ctsw_ctrl_chk.sv
module ctsw_ctrl_chk #(
  parameter int NT           = 4,
  parameter int FLUSH_CYCLES = 3,
  parameter int TW           = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_miss,
  input logic          ev_fpu,
  input logic          ev_io,
  input logic [TW-1:0] active_tid,
  input logic          issue_en,
  input logic          flush,
  input logic [NT-1:0] waiting
);
  int fl_run;

  always_ff @(posedge clk) begin
    if (!rst_n)     fl_run <= 0;
    else if (flush) fl_run <= fl_run + 1;
    else            fl_run <= 0;
  end

  p_event_parks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en && (ev_miss || ev_fpu || ev_io)) |=>
      (flush && !issue_en && $stable(active_tid) && waiting[active_tid]));

  p_flush_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (fl_run < FLUSH_CYCLES));

  p_flush_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush) |-> (fl_run == FLUSH_CYCLES));

  p_flush_tid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && $past(flush)) |-> $stable(active_tid));

  p_issue_eligible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |-> !waiting[active_tid]);

  p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_en && !flush && $past(!issue_en)) |-> $stable(active_tid));

  p_single_issue_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_en && flush));
endmodule

bind ctsw_ctrl ctsw_ctrl_chk #(
  .NT(NT), .FLUSH_CYCLES(FLUSH_CYCLES), .TW(TW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_miss    (ev_miss),
  .ev_fpu     (ev_fpu),
  .ev_io      (ev_io),
  .active_tid (active_tid),
  .issue_en   (issue_en),
  .flush      (flush),
  .waiting    (waiting)
);

// File: tb/ctsw_ctrl_tb.sv
module ctsw_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_miss = 1'b0, ev_fpu = 1'b0, ev_io = 1'b0;
  logic [3:0] ev_done = '0;
  logic [3:0] thr_ready = 4'b1111;
  logic [7:0] quantum = '0;
  logic [1:0] active_tid;
  logic       issue_en, flush;
  logic [3:0] waiting;

  ctsw_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ev_miss(ev_miss), .ev_fpu(ev_fpu), .ev_io(ev_io),
    .ev_done(ev_done), .thr_ready(thr_ready), .quantum(quantum),
    .active_tid(active_tid), .issue_en(issue_en), .flush(flush), .waiting(waiting)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int         at;
    logic [1:0] tid;
    logic       iss;
    logic       fl;
    logic [3:0] wt;
    string      req;
  } exp_t;

  exp_t q[$];
  int   edges = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;

  always @(posedge clk) edges <= edges + 1;

  // monitor: pops expectations once their edge has passed
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].at <= edges) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (active_tid !== e.tid || issue_en !== e.iss || flush !== e.fl || waiting !== e.wt) begin
          n_bad++;
          $display("FAIL %s: tid/iss/flush/wait actual=%0d/%0b/%0b/%b expected=%0d/%0b/%0b/%b",
                   e.req, active_tid, issue_en, flush, waiting, e.tid, e.iss, e.fl, e.wt);
        end
      end
    end
  end

  // driver: apply inputs for one cycle, queue the state expected after the edge
  task automatic row(input logic m, input logic f, input logic i, input logic [3:0] dn,
                     input logic [1:0] et, input logic ei, input logic ef,
                     input logic [3:0] ew, input string req);
    exp_t e;
    ev_miss = m; ev_fpu = f; ev_io = i; ev_done = dn;
    e.at = edges + 1; e.tid = et; e.iss = ei; e.fl = ef; e.wt = ew; e.req = req;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=still running expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    row(0,0,0,4'b0000, 2'd0,1,0,4'b0000, "R1");
    row(0,0,0,4'b0000, 2'd0,1,0,4'b0000, "R1");
    rst_n = 1'b1;
    // miss on thread 0, three flush cycles, then thread 1
    row(1,0,0,4'b0000, 2'd0,0,1,4'b0001, "R2");
    row(0,0,0,4'b0000, 2'd0,0,1,4'b0001, "R3/R12");
    row(0,0,0,4'b0000, 2'd0,0,1,4'b0001, "R3");
    row(0,0,0,4'b0000, 2'd1,1,0,4'b0001, "R4");
    // fpu on thread 1, thread 2 not ready -> thread 3
    thr_ready = 4'b1011;
    row(0,1,0,4'b0000, 2'd1,0,1,4'b0011, "R2");
    row(0,0,0,4'b0000, 2'd1,0,1,4'b0011, "R3");
    row(0,0,0,4'b0000, 2'd1,0,1,4'b0011, "R3");
    row(0,0,0,4'b0000, 2'd3,1,0,4'b0011, "R4");
    // completion of thread 0
    row(0,0,0,4'b0001, 2'd3,1,0,4'b0010, "R6");
    // io on thread 3, wrap to thread 0
    row(0,0,1,4'b0000, 2'd3,0,1,4'b1010, "R2");
    row(0,0,0,4'b0000, 2'd3,0,1,4'b1010, "R3");
    row(0,0,0,4'b0000, 2'd3,0,1,4'b1010, "R3");
    row(0,0,0,4'b0000, 2'd0,1,0,4'b1010, "R4");
    // nobody eligible after miss -> idle
    thr_ready = 4'b0001;
    row(1,0,0,4'b0000, 2'd0,0,1,4'b1011, "R2");
    row(0,0,0,4'b0000, 2'd0,0,1,4'b1011, "R3");
    row(0,0,0,4'b0000, 2'd0,0,1,4'b1011, "R3");
    row(0,0,0,4'b0000, 2'd0,0,0,4'b1011, "R5");
    row(0,1,0,4'b0010, 2'd0,0,0,4'b1001, "R11/R6");
    row(0,0,0,4'b0000, 2'd0,0,0,4'b1001, "R5");
    thr_ready = 4'b0011; quantum = 8'd3;
    row(0,0,0,4'b0000, 2'd1,1,0,4'b1001, "R5");
    // quantum 3, no other thread eligible: keeps issuing
    row(0,0,0,4'b0000, 2'd1,1,0,4'b1001, "R9");
    row(0,0,0,4'b0000, 2'd1,1,0,4'b1001, "R9");
    row(0,0,0,4'b0000, 2'd1,1,0,4'b1001, "R7");
    thr_ready = 4'b1111;
    row(0,0,0,4'b1000, 2'd1,1,0,4'b0001, "R9");
    row(0,0,0,4'b0000, 2'd1,1,0,4'b0001, "R9");
    row(0,0,0,4'b0000, 2'd1,0,1,4'b0001, "R7");
    row(0,1,0,4'b0000, 2'd1,0,1,4'b0001, "R11");
    row(0,0,0,4'b0000, 2'd1,0,1,4'b0001, "R3");
    row(0,0,0,4'b0000, 2'd2,1,0,4'b0001, "R4");
    // event in the expiry cycle: event wins
    row(0,0,0,4'b0000, 2'd2,1,0,4'b0001, "R9");
    row(0,0,0,4'b0000, 2'd2,1,0,4'b0001, "R9");
    row(1,0,0,4'b0000, 2'd2,0,1,4'b0101, "R10");
    row(0,0,0,4'b0000, 2'd2,0,1,4'b0101, "R3");
    row(0,0,0,4'b0000, 2'd2,0,1,4'b0101, "R3");
    row(0,0,0,4'b0000, 2'd3,1,0,4'b0101, "R4");
    // timeout with another ready, which drops during the flush: resume self
    row(0,0,0,4'b0000, 2'd3,1,0,4'b0101, "R9");
    row(0,0,0,4'b0000, 2'd3,1,0,4'b0101, "R9");
    row(0,0,0,4'b0000, 2'd3,0,1,4'b0101, "R7");
    thr_ready = 4'b1000;
    row(0,0,0,4'b0000, 2'd3,0,1,4'b0101, "R3");
    row(0,0,0,4'b0000, 2'd3,0,1,4'b0101, "R3");
    row(0,0,0,4'b0000, 2'd3,1,0,4'b0101, "R4");
    // quantum 0 disables the timeout
    quantum = 8'd0; thr_ready = 4'b1111;
    for (int k = 0; k < 12; k++)
      row(0,0,0,4'b0000, 2'd3,1,0,4'b0101, "R8");
    repeat (2) @(negedge clk);
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R1: pending expectations actual=%0d expected=0", q.size());
    end
    finish_run();
  end
endmodule